// File: doc/BRIEF.md
# Context-Tagged Fragment TLB

This block is a small, fully associative address translation cache for a GPU-style memory management unit. Each cached translation carries the 4-bit context id of the address space it belongs to. A translation covers an aligned region of 2^(12+fragment) bytes, so a single entry can map a large contiguous region instead of one 4 KiB page. A client presents a context id, a 40-bit virtual address and an access type. One cycle later the block reports one of three results: a translation with its physical address and memory attributes, a protection fault, or a miss.

On a miss, an external page table walker installs the entry through the refill port. The block chooses the slot itself. When software changes the mappings of an address space, it invalidates that whole context through the flush port. There is no way to invalidate a single entry.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, and every lookup misses until an entry is refilled.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high. The result reflects the entry contents before any refill or flush presented in the same cycle as the lookup.
- R3: An entry matches only if it is valid, its context id equals `lk_ctx`, and bits [39:12+fragment] of its stored virtual base equal those of `lk_va`. An entry of another context never matches.
- R4: The region of an entry spans 2^(12+fragment) bytes, with the 5-bit fragment field limited to the 40-bit space (a fragment of 28 or more covers every address). `rsp_pa` takes the stored physical base above bit 12+fragment and the virtual address bits below it. Refill address bits below that boundary are ignored.
- R5: A translated lookup returns the stored read, write, snoop and system-memory bits on `rsp_rd`, `rsp_wr`, `rsp_snoop` and `rsp_sys`.
- R6: A protection fault is a match whose permission bit for the requested access is clear. That bit is write when `lk_write`=1 and read when `lk_write`=0. A fault gives `rsp_fault`=1 and `rsp_hit`=0, and `rsp_pa` and the attributes are still driven from the matching entry.
- R7: On a miss, `rsp_hit`, `rsp_fault`, `rsp_pa` and all four attribute outputs are 0.
- R8: A flush clears every entry tagged with `flush_ctx` and leaves the entries of other contexts intact. The flush takes effect for lookups from the next cycle on.
- R9: A refill writes the lowest-numbered invalid entry. When all entries are valid, it writes the entry at a round-robin pointer instead. The pointer starts at 0 after reset, advances by one only on such replacements, and wraps from the last entry to 0.
- R10: A refill presented in the same cycle as a flush of the same context is discarded. A refill and a flush of different contexts in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ctx | input | 4 | Lookup context id |
| lk_va | input | 40 | Lookup virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result of last cycle's lookup is present |
| rsp_hit | output | 1 | Translation granted |
| rsp_fault | output | 1 | Matching entry denies the access |
| rsp_pa | output | 40 | Physical address |
| rsp_rd | output | 1 | Read permission of the matching entry |
| rsp_wr | output | 1 | Write permission of the matching entry |
| rsp_snoop | output | 1 | Snoop attribute of the matching entry |
| rsp_sys | output | 1 | System-memory attribute of the matching entry |
| fill_valid | input | 1 | Refill request |
| fill_ctx | input | 4 | Context of the new entry |
| fill_va | input | 40 | Virtual base of the new entry |
| fill_pa | input | 40 | Physical base of the new entry |
| fill_frag | input | 5 | Fragment size code |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_snoop | input | 1 | Snoop attribute |
| fill_sys | input | 1 | System-memory attribute |
| flush_valid | input | 1 | Flush request |
| flush_ctx | input | 4 | Context to invalidate |

## Verification
The bench targets the fragment mask at its edges: the last address inside a 2 MiB fragment, the first address past it, and the fragment that covers the whole space. A wrong mask width either leaks neighbouring pages into a hit or splits the fragment. Replacement is driven through a freed hole, then through several full-set evictions and a pointer wrap. A design that evicts while a slot is free, or that advances the pointer on non-replacing refills, evicts a page that should still translate. Refill and flush are collided in the same cycle, once for the same context and once for different contexts, and a lookup is raced against a refill. A design that keeps the colliding refill, or that forwards the new entry to the racing lookup, returns a translation where a miss is due.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  localparam int VA_W       = 40;
  localparam int CTX_W      = 4;
  localparam int FRAG_W     = 5;
  localparam int PAGE_SHIFT = 12;

  typedef struct packed {
    logic              vld;
    logic [CTX_W-1:0]  ctx;
    logic [VA_W-1:0]   vbase;
    logic [VA_W-1:0]   pbase;
    logic [FRAG_W-1:0] frag;
    logic              rd;
    logic              wr;
    logic              snoop;
    logic              sys;
  } tlb_ent_t;

  // ones on every address bit inside a fragment, clamped to the space
  function automatic logic [VA_W-1:0] frag_low_mask(input logic [FRAG_W-1:0] frag);
    int unsigned sh;
    logic [VA_W-1:0] one;
    one = 1;
    sh  = PAGE_SHIFT + int'(frag);
    if (sh >= VA_W) return '1;
    return (one << sh) - one;
  endfunction

  function automatic logic entry_covers(input tlb_ent_t e,
                                        input logic [CTX_W-1:0] ctx,
                                        input logic [VA_W-1:0] va);
    logic [VA_W-1:0] keep;
    keep = ~frag_low_mask(e.frag);
    return e.vld && (e.ctx == ctx) && (((e.vbase ^ va) & keep) == '0);
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input logic [VA_W-1:0] pbase,
                                              input logic [VA_W-1:0] va,
                                              input logic [FRAG_W-1:0] frag);
    logic [VA_W-1:0] m;
    m = frag_low_mask(frag);
    return (pbase & ~m) | (va & m);
  endfunction

endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
  import ctx_tlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  tlb_ent_t [NUM_ENT-1:0] ents,
  input  logic [CTX_W-1:0]       ctx,
  input  logic [VA_W-1:0]        va,
  output logic [NUM_ENT-1:0]     hit_vec,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       hit_idx
);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign hit_vec[g] = entry_covers(ents[g], ctx, va);
  end

  assign any_hit = |hit_vec;

  // lowest index wins when entries overlap
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               full
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             rr_step;

  always_comb begin
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign full       = &valid_vec;
  assign victim_idx = full ? rr_ptr : free_idx;
  assign rr_step    = take && full;

  always_ff @(posedge clk) begin
    if (!rst_n)       rr_ptr <= '0;
    else if (rr_step) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
  end

  p_free_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !full) |-> !valid_vec[victim_idx]);

  p_rr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_step |=> $stable(rr_ptr));

  p_rr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_step && rr_ptr == LAST) |=> (rr_ptr == '0));

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [VA_W-1:0]   rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_snoop,
  output logic              rsp_sys,
  input  logic              fill_valid,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [VA_W-1:0]   fill_pa,
  input  logic [FRAG_W-1:0] fill_frag,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              fill_snoop,
  input  logic              fill_sys,
  input  logic              flush_valid,
  input  logic [CTX_W-1:0]  flush_ctx
);

  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  tlb_ent_t [NUM_ENT-1:0] ents;
  logic     [NUM_ENT-1:0] valid_vec;
  logic     [NUM_ENT-1:0] lk_hit_vec;
  logic                   lk_match_any;
  logic     [IDX_W-1:0]   lk_idx;
  tlb_ent_t               lk_ent;
  logic                   lk_perm_ok;
  logic                   fill_drop;
  logic                   fill_go;
  logic     [IDX_W-1:0]   victim_idx;
  logic                   set_full;
  tlb_ent_t               new_ent;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_vld
    assign valid_vec[g] = ents[g].vld;
  end

  ctx_tlb_match #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_match (
    .ents    (ents),
    .ctx     (lk_ctx),
    .va      (lk_va),
    .hit_vec (lk_hit_vec),
    .any_hit (lk_match_any),
    .hit_idx (lk_idx)
  );

  assign fill_drop = fill_valid && flush_valid && (flush_ctx == fill_ctx);
  assign fill_go   = fill_valid && !fill_drop;

  ctx_tlb_victim #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .take       (fill_go),
    .victim_idx (victim_idx),
    .full       (set_full)
  );

  // refill addresses are stored aligned to their fragment
  always_comb begin
    new_ent       = '0;
    new_ent.vld   = 1'b1;
    new_ent.ctx   = fill_ctx;
    new_ent.vbase = fill_va & ~frag_low_mask(fill_frag);
    new_ent.pbase = fill_pa & ~frag_low_mask(fill_frag);
    new_ent.frag  = fill_frag;
    new_ent.rd    = fill_rd;
    new_ent.wr    = fill_wr;
    new_ent.snoop = fill_snoop;
    new_ent.sys   = fill_sys;
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (fill_go && victim_idx == IDX_W'(g)) begin
        ents[g] <= new_ent;
      end else if (flush_valid && ents[g].ctx == flush_ctx) begin
        ents[g].vld <= 1'b0;
      end
    end
  end

  assign lk_ent     = ents[lk_idx];
  assign lk_perm_ok = lk_write ? lk_ent.wr : lk_ent.rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_snoop <= 1'b0;
      rsp_sys   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_match_any && lk_perm_ok;
      rsp_fault <= lk_valid && lk_match_any && !lk_perm_ok;
      if (lk_valid && lk_match_any) begin
        rsp_pa    <= join_pa(lk_ent.pbase, lk_va, lk_ent.frag);
        rsp_rd    <= lk_ent.rd;
        rsp_wr    <= lk_ent.wr;
        rsp_snoop <= lk_ent.snoop;
        rsp_sys   <= lk_ent.sys;
      end else begin
        rsp_pa    <= '0;
        rsp_rd    <= 1'b0;
        rsp_wr    <= 1'b0;
        rsp_snoop <= 1'b0;
        rsp_sys   <= 1'b0;
      end
    end
  end

  // ---- checks ----
  logic [CTX_W-1:0]   flush_ctx_q;
  logic [NUM_ENT-1:0] flush_residue;

  always_ff @(posedge clk) begin
    if (!rst_n) flush_ctx_q <= '0;
    else        flush_ctx_q <= flush_ctx;
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_res
    assign flush_residue[g] = ents[g].vld && (ents[g].ctx == flush_ctx_q);
  end

  p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  p_hit_or_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  p_fault_has_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_match_any |=> !rsp_fault && !rsp_hit);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_fault) |->
      (rsp_pa == '0 && !rsp_rd && !rsp_wr && !rsp_snoop && !rsp_sys));

  p_flush_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (flush_residue == '0));

  p_drop_no_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_drop |=> $countones(valid_vec) <= $past($countones(valid_vec)));

endmodule

// File: tb/ctx_tlb_tb.sv
module ctx_tlb_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [3:0]  lk_ctx;
  logic [39:0] lk_va;
  logic        lk_write;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [39:0] rsp_pa;
  logic        rsp_rd, rsp_wr, rsp_snoop, rsp_sys;
  logic        fill_valid;
  logic [3:0]  fill_ctx;
  logic [39:0] fill_va, fill_pa;
  logic [4:0]  fill_frag;
  logic        fill_rd, fill_wr, fill_snoop, fill_sys;
  logic        flush_valid;
  logic [3:0]  flush_ctx;

  int n_tests = 0;
  int n_fail  = 0;

  logic        r_hit, r_fault;
  logic [39:0] r_pa;
  logic [3:0]  r_attr;

  always #10 clk = ~clk;

  ctx_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ctx(lk_ctx), .lk_va(lk_va), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_snoop(rsp_snoop), .rsp_sys(rsp_sys),
    .fill_valid(fill_valid), .fill_ctx(fill_ctx), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_frag(fill_frag), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .fill_snoop(fill_snoop), .fill_sys(fill_sys),
    .flush_valid(flush_valid), .flush_ctx(flush_ctx)
  );

  task automatic chk(input logic ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_ctx = 0; lk_va = 0; lk_write = 0;
    fill_valid = 0; fill_ctx = 0; fill_va = 0; fill_pa = 0; fill_frag = 0;
    fill_rd = 0; fill_wr = 0; fill_snoop = 0; fill_sys = 0;
    flush_valid = 0; flush_ctx = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // drives at a falling edge, result is read one falling edge later
  task automatic lookup(input logic [3:0] c, input logic [39:0] va, input logic wr);
    @(negedge clk);
    lk_valid = 1; lk_ctx = c; lk_va = va; lk_write = wr;
    @(negedge clk);
    lk_valid = 0;
    r_hit = rsp_hit; r_fault = rsp_fault; r_pa = rsp_pa;
    r_attr = {rsp_rd, rsp_wr, rsp_snoop, rsp_sys};
  endtask

  task automatic set_fill(input logic [3:0] c, input logic [39:0] va, input logic [39:0] pa,
                          input logic [4:0] fr, input logic [3:0] attr);
    fill_valid = 1; fill_ctx = c; fill_va = va; fill_pa = pa; fill_frag = fr;
    {fill_rd, fill_wr, fill_snoop, fill_sys} = attr;
  endtask

  task automatic refill(input logic [3:0] c, input logic [39:0] va, input logic [39:0] pa,
                        input logic [4:0] fr, input logic [3:0] attr);
    @(negedge clk);
    set_fill(c, va, pa, fr, attr);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic flush(input logic [3:0] c);
    @(negedge clk);
    flush_valid = 1; flush_ctx = c;
    @(negedge clk);
    flush_valid = 0;
  endtask

  task automatic expect_hit(input logic [3:0] c, input logic [39:0] va, input logic [39:0] pa, input string tag);
    lookup(c, va, 0);
    chk(r_hit === 1'b1, {tag, " hit"}, 40'(r_hit), 40'd1);
    chk(r_pa === pa, {tag, " pa"}, r_pa, pa);
  endtask

  task automatic expect_miss(input logic [3:0] c, input logic [39:0] va, input string tag);
    lookup(c, va, 0);
    chk(r_hit === 1'b0 && r_fault === 1'b0, {tag, " miss"}, 40'({r_hit, r_fault}), 40'd0);
  endtask

  task automatic t_reset();
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 40'(rsp_valid), 40'd0);
    expect_miss(4'd0, 40'h0, "R1 empty");
    expect_miss(4'd15, 40'hFF_FFFF_F000, "R1 empty");
  endtask

  task automatic t_basic();
    refill(4'd3, 40'h12_3456_7000, 40'hAB_CDEF_1000, 5'd0, 4'b1110);
    lookup(4'd3, 40'h12_3456_7ABC, 0);
    chk(r_hit === 1'b1, "R3 same ctx hit", 40'(r_hit), 40'd1);
    chk(r_pa === 40'hAB_CDEF_1ABC, "R4 4K pa", r_pa, 40'hAB_CDEF_1ABC);
    chk(r_attr === 4'b1110, "R5 attributes", 40'(r_attr), 40'hE);
    expect_miss(4'd4, 40'h12_3456_7ABC, "R3 other ctx");
    lookup(4'd3, 40'h12_3456_8000, 0);
    chk(!r_hit && !r_fault, "R4 next page", 40'(r_hit), 40'd0);
    chk(r_pa === 40'h0 && r_attr === 4'h0, "R7 miss zero", r_pa, 40'h0);
  endtask

  task automatic t_frag();
    // 2 MiB fragment, junk low bits on the refill addresses
    refill(4'd5, 40'h40_0020_1234, 40'h00_8060_0ABC, 5'd9, 4'b1001);
    expect_hit(4'd5, 40'h40_003F_FFF8, 40'h00_807F_FFF8, "R4 frag top");
    expect_hit(4'd5, 40'h40_0020_0000, 40'h00_8060_0000, "R4 frag base");
    expect_miss(4'd5, 40'h40_0040_0000, "R4 past frag");
    expect_miss(4'd5, 40'h40_001F_FFFF, "R4 below frag");
    refill(4'd7, 40'h0, 40'h0, 5'd31, 4'b1100);
    expect_hit(4'd7, 40'hFF_FFFF_F123, 40'hFF_FFFF_F123, "R4 whole space");
  endtask

  task automatic t_fault();
    refill(4'd2, 40'h00_0000_1000, 40'h00_0055_5000, 5'd0, 4'b1000);
    lookup(4'd2, 40'h00_0000_1010, 0);
    chk(r_hit === 1'b1 && r_fault === 1'b0, "R6 read allowed", 40'({r_hit, r_fault}), 40'd2);
    lookup(4'd2, 40'h00_0000_1010, 1);
    chk(r_hit === 1'b0 && r_fault === 1'b1, "R6 write fault", 40'({r_hit, r_fault}), 40'd1);
    chk(r_pa === 40'h00_0055_5010, "R6 fault pa", r_pa, 40'h00_0055_5010);
    chk(r_attr === 4'b1000, "R6 fault attrs", 40'(r_attr), 40'h8);
  endtask

  task automatic t_flush();
    flush(4'd3);
    expect_miss(4'd3, 40'h12_3456_7000, "R8 flushed ctx");
    expect_hit(4'd5, 40'h40_0020_0010, 40'h00_8060_0010, "R8 other ctx kept");
    expect_hit(4'd2, 40'h00_0000_1000, 40'h00_0055_5000, "R8 other ctx kept");
  endtask

  task automatic t_race();
    // lookup in the same cycle as its refill sees the old state
    @(negedge clk);
    lk_valid = 1; lk_ctx = 4'd8; lk_va = 40'h00_0777_7000; lk_write = 0;
    set_fill(4'd8, 40'h00_0777_7000, 40'h00_0111_1000, 5'd0, 4'b1100);
    @(negedge clk);
    lk_valid = 0; fill_valid = 0;
    chk(rsp_hit === 1'b0, "R2 same-cycle lookup", 40'(rsp_hit), 40'd0);
    expect_hit(4'd8, 40'h00_0777_7000, 40'h00_0111_1000, "R2 next lookup");
    // collisions
    @(negedge clk);
    set_fill(4'd9, 40'h00_0999_0000, 40'h00_0222_0000, 5'd0, 4'b1100);
    flush_valid = 1; flush_ctx = 4'd9;
    @(negedge clk);
    fill_valid = 0; flush_valid = 0;
    expect_miss(4'd9, 40'h00_0999_0000, "R10 same ctx dropped");
    @(negedge clk);
    set_fill(4'd10, 40'h00_0AAA_0000, 40'h00_0333_0000, 5'd0, 4'b1100);
    flush_valid = 1; flush_ctx = 4'd5;
    @(negedge clk);
    fill_valid = 0; flush_valid = 0;
    expect_hit(4'd10, 40'h00_0AAA_0000, 40'h00_0333_0000, "R10 other ctx fill kept");
    expect_miss(4'd5, 40'h40_0020_0000, "R10 other ctx flushed");
  endtask

  function automatic logic [39:0] pg(input int p);
    return 40'(p) << 12;
  endfunction

  function automatic logic [39:0] pp(input int p);
    return (40'(p) << 12) | 40'h10_0000_0000;
  endfunction

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 8; i++) refill((i == 3) ? 4'd2 : 4'd1, pg(i), pp(i), 5'd0, 4'b1100);
    flush(4'd2);
    refill(4'd1, pg(20), pp(20), 5'd0, 4'b1100); // into the hole
    expect_hit(4'd1, pg(0), pp(0), "R9 invalid first");
    expect_hit(4'd1, pg(20), pp(20), "R9 hole filled");
    refill(4'd1, pg(21), pp(21), 5'd0, 4'b1100); // evicts slot 0
    expect_miss(4'd1, pg(0), "R9 rr slot0");
    expect_hit(4'd1, pg(1), pp(1), "R9 rr slot1 kept");
    refill(4'd1, pg(22), pp(22), 5'd0, 4'b1100); // evicts slot 1
    expect_miss(4'd1, pg(1), "R9 rr slot1");
    expect_hit(4'd1, pg(2), pp(2), "R9 rr slot2 kept");
    for (int i = 23; i < 29; i++) refill(4'd1, pg(i), pp(i), 5'd0, 4'b1100); // slots 2..7
    expect_miss(4'd1, pg(20), "R9 rr slot3");
    expect_hit(4'd1, pg(21), pp(21), "R9 before wrap");
    refill(4'd1, pg(29), pp(29), 5'd0, 4'b1100); // wraps to slot 0
    expect_miss(4'd1, pg(21), "R9 wrap slot0");
    expect_hit(4'd1, pg(22), pp(22), "R9 wrap slot1 kept");
    expect_hit(4'd1, pg(29), pp(29), "R9 wrap new");
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_frag();
    t_fault();
    t_flush();
    t_race();
    t_replace();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule